// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block accepts writes to a software-interrupt generation register and turns each one into pending software interrupts at a set of CPUs. A write carries an interrupt number, an eight-bit CPU list and a two-bit filter mode. The requesting CPU's number arrives on a sideband input with the write. The filter mode picks the targets in one of three ways: the explicit list, every online CPU except the requester, or only the requester. The fourth mode code is reserved and does nothing. Only CPUs below the online count can be targeted.

For every targeted CPU the block keeps one entry per interrupt number, 16 in all. An entry has a pending flag and a bitmap of the CPUs that raised it. Each new request ORs the requester's bit into that bitmap. A CPU interface acknowledges an entry through a clear port, which empties that entry. The generation register always reads as zero. Choosing between pending interrupts and delivering them to a CPU is done elsewhere.

Top module: `sgi_dispatch`

## Requirements
- R1: The write word is decoded as follows. The interrupt number is bits [3:0]. The CPU list is bits [23:16], with bit 16+n selecting CPU n. The filter mode is bits [25:24]. All other bits have no effect.
- R2: With filter mode 0, the CPUs in the list are targeted. Any list bit n with n at or above online_cnt is dropped. An online_cnt above NUM_CPUS counts as NUM_CPUS.
- R3: With filter mode 1, every CPU below online_cnt is targeted except wr_cpu. The CPU list is ignored.
- R4: With filter mode 2, only wr_cpu is targeted, and only if wr_cpu is below online_cnt. The CPU list is ignored.
- R5: A write with filter mode 3 changes no pending flag and no source bitmap.
- R6: A write at a clock edge sets the pending flag of (target, number) for every targeted CPU. It also sets bit wr_cpu of that entry's source bitmap. Both are visible right after that edge. The pending flag is pend_o[cpu*16+id], and the source bit is src_o[(cpu*16+id)*8+src].
- R7: The source bitmap accumulates. A later request from another CPU keeps the earlier source bits. An entry is pending exactly when its source bitmap is non-zero.
- R8: A clear (clr_en with clr_cpu and clr_id) empties the pending flag and source bitmap of that entry at the next edge. Other entries are not touched.
- R9: If a set and a clear reach the same entry in the same cycle, the set wins. The entry stays pending, and its bitmap is the old bits ORed with the new source bit.
- R10: rd_data, the read value of the generation register, is zero at all times.
- R11: After reset, every pending flag and every source bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the generation register |
| wr_data | input | 32 | Write word (number, CPU list, filter mode) |
| wr_cpu | input | 3 | Number of the CPU issuing the write |
| online_cnt | input | 4 | Number of online CPUs |
| clr_en | input | 1 | Clear strobe from a CPU interface |
| clr_cpu | input | 3 | CPU of the entry to clear |
| clr_id | input | 4 | Interrupt number of the entry to clear |
| rd_data | output | 32 | Read value of the generation register |
| pend_o | output | 128 | Pending flags, index cpu*16+id |
| src_o | output | 1024 | Source bitmaps, index (cpu*16+id)*8+src |

## Verification
Some properties are checked on every cycle. The decoded target set never reaches an offline CPU. Mode 1 never includes the requester. Mode 2 holds at most the requester. Mode 3 yields no target. In each entry bank, a set hit leaves the entry pending with the new source bit. A clear alone empties the entry. A collision keeps it pending. A pending flag always agrees with a non-zero bitmap.

Other behaviour only the bench scenarios can show. These are that unused write bits really have no effect, and that an online count above the CPU count is clamped. The bench also shows that bitmaps accumulate across many requesters. Finally, it shows that no entry other than the addressed one moves, by comparing all 128 entries after every step against a model.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int SGI_ID_W   = 4;
    localparam int SGI_LIST_W = 8;
    localparam int SGI_CPU_W  = 3;

    // Field positions inside the write word
    localparam int FLD_ID_LSB   = 0;
    localparam int FLD_LIST_LSB = 16;
    localparam int FLD_MODE_LSB = 24;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } sgi_filter_e;

    typedef struct packed {
        logic                  valid;
        logic [SGI_ID_W-1:0]   id;
        logic [SGI_LIST_W-1:0] tgt;
        logic [SGI_CPU_W-1:0]  src;
    } sgi_req_t;

endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int CPU_W    = $clog2(NUM_CPUS),
    parameter int CNT_W    = $clog2(NUM_CPUS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic [CNT_W-1:0] online_cnt,
    output sgi_req_t         req
);

    sgi_filter_e           mode;
    logic [SGI_LIST_W-1:0] online_mask;
    logic [SGI_LIST_W-1:0] self_bit;
    logic [SGI_LIST_W-1:0] list;
    logic                  unused_bits;

    assign unused_bits = ^{wr_data[31:26], wr_data[15:4]};

    always_comb begin
        mode = sgi_filter_e'(wr_data[FLD_MODE_LSB +: 2]);
        list = wr_data[FLD_LIST_LSB +: SGI_LIST_W];
        self_bit = SGI_LIST_W'(1) << wr_cpu;
        online_mask = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            online_mask[i] = (CNT_W'(i) < online_cnt);
        end
    end

    always_comb begin
        req.valid = wr_en && (mode != FLT_RSVD);
        req.id    = wr_data[FLD_ID_LSB +: SGI_ID_W];
        req.src   = SGI_CPU_W'(wr_cpu);
        unique case (mode)
            FLT_LIST:   req.tgt = list & online_mask;
            FLT_OTHERS: req.tgt = online_mask & ~self_bit;
            FLT_SELF:   req.tgt = self_bit & online_mask;
            default:    req.tgt = '0;
        endcase
        if (!req.valid) begin
            req.tgt = '0;
        end
    end

    AST_ONLINE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req.tgt & ~online_mask) == '0);  // R2
    AST_OTHERS_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == FLT_OTHERS) |-> (req.tgt & self_bit) == '0);  // R3
    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == FLT_SELF) |-> (req.tgt & ~self_bit) == '0);  // R4
    AST_RSVD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == FLT_RSVD) |-> req.tgt == '0);  // R5

endmodule

// File: rtl/sgi_cpu_bank.sv
module sgi_cpu_bank
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_IDS  = 16,
    parameter int CPU_IDX  = 0,
    parameter int CPU_W    = $clog2(NUM_CPUS),
    parameter int ID_W     = $clog2(NUM_IDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  sgi_req_t                     req,
    input  logic                         clr_en,
    input  logic [CPU_W-1:0]             clr_cpu,
    input  logic [ID_W-1:0]              clr_id,
    output logic [NUM_IDS-1:0]           pend,
    output logic [NUM_IDS*NUM_CPUS-1:0]  src
);

    typedef struct packed {
        logic [NUM_IDS-1:0]               pend;
        logic [NUM_IDS-1:0][NUM_CPUS-1:0] src;
    } bank_state_t;

    bank_state_t         st_d, st_q;
    logic [NUM_IDS-1:0]  set_hit;
    logic [NUM_IDS-1:0]  clr_hit;
    logic [NUM_CPUS-1:0] src_onehot;

    always_comb begin
        src_onehot = NUM_CPUS'(1) << req.src;
        for (int i = 0; i < NUM_IDS; i++) begin
            set_hit[i] = req.valid && req.tgt[CPU_IDX] && (req.id == SGI_ID_W'(i));
            clr_hit[i] = clr_en && (clr_cpu == CPU_W'(CPU_IDX)) && (clr_id == ID_W'(i));
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (set_hit[i]) begin
                st_d.pend[i] = 1'b1;
                st_d.src[i]  = st_q.src[i] | src_onehot;
            end else if (clr_hit[i]) begin
                st_d.pend[i] = 1'b0;
                st_d.src[i]  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign src  = st_q.src;

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_chk
        AST_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
            set_hit[g] |=> st_q.pend[g] &&
                ((st_q.src[g] & $past(src_onehot)) == $past(src_onehot)));  // R6
        AST_PEND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.pend[g] == (st_q.src[g] != '0));  // R7
        AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[g] && !set_hit[g]) |=> !st_q.pend[g] && st_q.src[g] == '0);  // R8
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[g] && set_hit[g]) |=> st_q.pend[g] &&
                ((st_q.src[g] & $past(st_q.src[g])) == $past(st_q.src[g])));  // R9
    end

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_IDS  = 16,
    localparam int CPU_W   = $clog2(NUM_CPUS),
    localparam int ID_W    = $clog2(NUM_IDS),
    localparam int CNT_W   = $clog2(NUM_CPUS + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [31:0]                          wr_data,
    input  logic [CPU_W-1:0]                     wr_cpu,
    input  logic [CNT_W-1:0]                     online_cnt,
    input  logic                                 clr_en,
    input  logic [CPU_W-1:0]                     clr_cpu,
    input  logic [ID_W-1:0]                      clr_id,
    output logic [31:0]                          rd_data,
    output logic [NUM_CPUS*NUM_IDS-1:0]          pend_o,
    output logic [NUM_CPUS*NUM_IDS*NUM_CPUS-1:0] src_o
);

    localparam int BANK_SRC_W = NUM_IDS * NUM_CPUS;

    sgi_req_t req;

    // The generation register is write-only; reads return zero (R10)
    assign rd_data = '0;

    sgi_decode #(
        .NUM_CPUS (NUM_CPUS)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_cpu     (wr_cpu),
        .online_cnt (online_cnt),
        .req        (req)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
        sgi_cpu_bank #(
            .NUM_CPUS (NUM_CPUS),
            .NUM_IDS  (NUM_IDS),
            .CPU_IDX  (c)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req),
            .clr_en  (clr_en),
            .clr_cpu (clr_cpu),
            .clr_id  (clr_id),
            .pend    (pend_o[c*NUM_IDS +: NUM_IDS]),
            .src     (src_o[c*BANK_SRC_W +: BANK_SRC_W])
        );
    end

endmodule

// File: tb/tb_sgi_dispatch.sv
`timescale 1ns/1ps
module tb_sgi_dispatch;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_en = 0;
    logic [31:0]   wr_data = '0;
    logic [2:0]    wr_cpu = '0;
    logic [3:0]    online_cnt = 4'd8;
    logic          clr_en = 0;
    logic [2:0]    clr_cpu = '0;
    logic [3:0]    clr_id = '0;
    logic [31:0]   rd_data;
    logic [127:0]  pend_o;
    logic [1023:0] src_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic       pend_m [8][16];
    logic [7:0] src_m  [8][16];

    always #2.5 clk = ~clk;

    sgi_dispatch dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_cpu(wr_cpu), .online_cnt(online_cnt), .clr_en(clr_en),
        .clr_cpu(clr_cpu), .clr_id(clr_id), .rd_data(rd_data),
        .pend_o(pend_o), .src_o(src_o)
    );

    function automatic logic [31:0] mk(logic [1:0] mode, logic [7:0] list, logic [3:0] id);
        return {6'd0, mode, list, 12'd0, id};
    endfunction

    function automatic logic [7:0] exp_targets(logic [31:0] d, logic [2:0] c, logic [3:0] n);
        logic [7:0] mask;
        int eff;
        eff  = (n > 8) ? 8 : int'(n);
        mask = (eff == 8) ? 8'hFF : 8'((1 << eff) - 1);
        case (d[25:24])
            2'd0:    return d[23:16] & mask;
            2'd1:    return mask & ~(8'h1 << c);
            2'd2:    return (8'h1 << c) & mask;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [127:0] exp_pend();
        logic [127:0] v;
        for (int cp = 0; cp < 8; cp++)
            for (int id = 0; id < 16; id++)
                v[cp*16+id] = pend_m[cp][id];
        return v;
    endfunction

    function automatic logic [1023:0] exp_src();
        logic [1023:0] v;
        for (int cp = 0; cp < 8; cp++)
            for (int id = 0; id < 16; id++)
                v[(cp*16+id)*8 +: 8] = src_m[cp][id];
        return v;
    endfunction

    task automatic check_all(string tag);
        checks++;
        if (pend_o !== exp_pend()) begin
            fails++;
            $display("FAIL %s pending: actual %h expected %h", tag, pend_o, exp_pend());
        end
        checks++;
        if (src_o !== exp_src()) begin
            fails++;
            $display("FAIL %s source: actual %h expected %h", tag, src_o, exp_src());
        end
        checks++;
        if (rd_data !== 32'd0) begin
            fails++;
            $display("FAIL R10 read value: actual %h expected 00000000", rd_data);
        end
    endtask

    task automatic step(logic we, logic [31:0] d, logic [2:0] c,
                        logic ce, logic [2:0] cc, logic [3:0] ci, string tag);
        logic [7:0] tgt;
        logic sh, chit;
        @(negedge clk);
        wr_en = we; wr_data = d; wr_cpu = c;
        clr_en = ce; clr_cpu = cc; clr_id = ci;
        tgt = we ? exp_targets(d, c, online_cnt) : 8'h00;
        for (int cp = 0; cp < 8; cp++) begin
            for (int id = 0; id < 16; id++) begin
                sh   = tgt[cp] && (d[3:0] == 4'(id));
                chit = ce && (cc == 3'(cp)) && (ci == 4'(id));
                if (sh) begin
                    pend_m[cp][id] = 1'b1;
                    src_m[cp][id]  = src_m[cp][id] | (8'h1 << c);
                end else if (chit) begin
                    pend_m[cp][id] = 1'b0;
                    src_m[cp][id]  = 8'h00;
                end
            end
        end
        @(posedge clk);
        #1;
        check_all(tag);
        wr_en = 0; clr_en = 0;
    endtask

    task automatic wr(logic [31:0] d, logic [2:0] c, string tag);
        step(1'b1, d, c, 1'b0, 3'd0, 4'd0, tag);
    endtask

    task automatic clr(logic [2:0] cc, logic [3:0] ci, string tag);
        step(1'b0, 32'd0, 3'd0, 1'b1, cc, ci, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int cp = 0; cp < 8; cp++)
            for (int id = 0; id < 16; id++) begin
                pend_m[cp][id] = 1'b0;
                src_m[cp][id]  = 8'h00;
            end
        repeat (3) @(posedge clk);
        #1;
        check_all("R11 reset state");
        @(negedge clk);
        rst_n = 1;

        // R1: junk in unused bits, list mode, id 5
        wr(32'hFC00_FFF5 & ~32'h0300_0000 | 32'h0012_0000, 3'd1, "R1 field decode");
        // R2: list masked by online count 3
        online_cnt = 4'd3;
        wr(mk(2'd0, 8'hFF, 4'd2), 3'd0, "R2 list masked");
        // R2: online count above CPU count clamps
        online_cnt = 4'd15;
        wr(mk(2'd0, 8'h80, 4'd3), 3'd4, "R2 clamp");
        // R3: all but requester, list ignored
        online_cnt = 4'd6;
        wr(mk(2'd1, 8'h00, 4'd7), 3'd2, "R3 others");
        // R4: only requester, list ignored
        wr(mk(2'd2, 8'hFF, 4'd9), 3'd5, "R4 self");
        // R4: offline requester gets nothing
        wr(mk(2'd2, 8'hFF, 4'd10), 3'd7, "R4 self offline");
        // R5: reserved mode has no effect
        wr(mk(2'd3, 8'hFF, 4'd11), 3'd1, "R5 reserved");
        // R6 and R7: two requesters accumulate on the same entry
        online_cnt = 4'd8;
        wr(mk(2'd0, 8'h01, 4'd12), 3'd3, "R6 set");
        wr(mk(2'd0, 8'h01, 4'd12), 3'd6, "R7 accumulate");
        // R8: clear empties only that entry
        clr(3'd0, 4'd12, "R8 clear");
        clr(3'd0, 4'd12, "R8 clear idle entry");
        // R9: set and clear on the same entry in one cycle
        wr(mk(2'd0, 8'h04, 4'd14), 3'd0, "R9 prep");
        step(1'b1, mk(2'd0, 8'h04, 4'd14), 3'd1, 1'b1, 3'd2, 4'd14, "R9 set wins");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] d;
            d = $urandom;
            online_cnt = 4'($urandom_range(0, 10));
            step($urandom_range(0, 3) != 0, d, 3'($urandom), $urandom_range(0, 2) == 0,
                 3'($urandom), 4'($urandom), "R6 random mix");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule